// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block is a management-bus target that accepts Clause-22 MDIO frames and turns them into accesses to a 32-bit internal register space. The 5-bit PHY address is not used as a PHY address. Its two upper bits pick how the frame is handled, and its three lower bits join the register number and a 10-bit page to form a byte address. One 16-bit MDIO access reaches one half of one 32-bit register.

A host first writes the page, then reaches any register in the 512-byte window that the page selects. It always writes the low half and then the high half of a register, and always reads the low half and then the high half. Writes are merged into one 32-bit bus write. A low-half read fetches the whole word and keeps the upper half, so the two halves the host sees come from the same bus read. Frames of any other mode only raise a strobe for a separate PHY path.

The MDC and MDIO pins are sampled in the system clock domain through a synchronizer. The internal bus is a single-cycle strobe interface: read data is returned in the same cycle as the read strobe.

Top module: `mdio_paged_bridge`

## Requirements
- R1: PHY address bits [4:3] set the mode: 3 selects page mode and 2 selects register mode. Any other value produces a one-cycle `bypass_stb` pulse after the header, with no bus access and no MDIO drive.
- R2: A page-mode write stores data bits [9:0] as the page. Reset clears the page to 0.
- R3: In register mode the byte address is {page, PHY address [2:0], register number, 0}. Register number bit 0 (address bit 1) selects the half: 0 is the low half and 1 is the high half. `reg_addr` carries the 32-bit aligned word address, with bits [1:0] at 0.
- R4: A register-mode write to a low half produces no bus write. It only stages the 16 data bits and the word address.
- R5: A high-half write to the staged word issues exactly one bus write with data {high, staged low}. A high-half write to any other word is dropped.
- R6: A register-mode low-half read issues one bus read, returns bits [15:0] on MDIO and keeps bits [31:16] with the word address.
- R7: A high-half read of the kept word returns the kept bits without a bus read, and this consumes them. A high-half read of any other word issues a fresh bus read and returns bits [31:16].
- R8: A frame is accepted only after at least PRE_MIN consecutive ones, followed by start bits 0 and 1 and an opcode of 10 (read) or 01 (write). Data follows MSB first. Any other opcode, or a shorter preamble, makes the frame have no effect.
- R9: On an accepted register-mode read, `mdio_oe` stays low in the first turnaround bit. The block drives 0 in the second turnaround bit, then 16 data bits MSB first, each changing after a falling MDC edge. It releases the line on the falling edge that follows the last data bit.
- R10: A page-mode read does not drive MDIO and makes no bus access, because the page is not readable.
- R11: `reg_wr` and `reg_rd` are never high together, and each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mdc | input | 1 | Management clock pin |
| mdio_in | input | 1 | Management data pin, receive side |
| mdio_out | output | 1 | Management data value driven during reads |
| mdio_oe | output | 1 | Output enable for the data pin |
| bypass_stb | output | 1 | One-cycle pulse for frames meant for the PHY path |
| reg_wr | output | 1 | Internal bus write strobe |
| reg_rd | output | 1 | Internal bus read strobe |
| reg_addr | output | 19 | Internal bus byte address, word aligned |
| reg_wdata | output | 32 | Internal bus write data |
| reg_rdata | input | 32 | Internal bus read data, valid with `reg_rd` |

## Verification
A pin edge reaches the decoder after two synchronizer flops and an edge register. As a result, the bus write strobe follows the rising MDC edge of the last data bit by four clock edges, and each driven MDIO bit follows its falling MDC edge by three. The bench holds every MDC level for eight clocks. It samples the data pin just before each rising edge and checks the bus queue eight clocks after a frame ends, so every result has settled before it is compared. A behavioural model of the page, the write stage and the read hold predicts each bus strobe. That prediction is compared on every clock against the strobes the block produces, which also catches strobes nobody expected.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;

    localparam int PAGE_W   = 10;
    localparam int HALF_W   = 16;
    localparam int WORD_W   = 2 * HALF_W;
    localparam int PHY_LO_W = 3;
    localparam int REGN_W   = 5;
    localparam int HDR_W    = 2 + 5 + REGN_W;
    localparam int WORD_AW  = PAGE_W + PHY_LO_W + REGN_W - 1;
    localparam int ADDR_W   = WORD_AW + 2;

    typedef enum logic [1:0] {
        MODE_BYPASS = 2'd0,
        MODE_RSVD   = 2'd1,
        MODE_REG    = 2'd2,
        MODE_PAGE   = 2'd3
    } mode_e;

    typedef struct packed {
        mode_e                 mode;
        logic [PHY_LO_W-1:0]   phy_lo;
        logic [REGN_W-1:0]     regn;
        logic [HALF_W-1:0]     data;
    } mdio_req_t;

    // Word index of a register: page, low PHY bits, register number without the half bit
    function automatic logic [WORD_AW-1:0] word_of(input logic [PAGE_W-1:0]   pg,
                                                   input logic [PHY_LO_W-1:0] pl,
                                                   input logic [REGN_W-2:0]   rn_hi);
        return {pg, pl, rn_hi};
    endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic mdc_rise,
    output logic mdc_fall,
    output logic mdio_s
);
    logic [STAGES-1:0] mdc_sh;
    logic [STAGES-1:0] mdio_sh;
    logic              mdc_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_sh   <= '0;
            mdio_sh  <= '0;
            mdc_last <= 1'b0;
        end else begin
            mdc_sh   <= {mdc_sh[STAGES-2:0], mdc_i};
            mdio_sh  <= {mdio_sh[STAGES-2:0], mdio_i};
            mdc_last <= mdc_sh[STAGES-1];
        end
    end

    assign mdc_rise = mdc_sh[STAGES-1] & ~mdc_last;
    assign mdc_fall = ~mdc_sh[STAGES-1] & mdc_last;
    assign mdio_s   = mdio_sh[STAGES-1];

endmodule

// File: rtl/mdio_frame_rx.sv
module mdio_frame_rx
    import mdio_bridge_pkg::*;
#(
    parameter int PRE_MIN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              mdio_s,
    input  logic [HALF_W-1:0] rd_half,
    output logic              wr_evt,
    output logic              rd_evt,
    output mdio_req_t         req,
    output logic              bypass_stb,
    output logic              mdio_out,
    output logic              mdio_oe
);
    localparam int PW = $clog2(PRE_MIN + 1);

    typedef enum logic [2:0] {
        ST_PRE, ST_START, ST_HDR, ST_WDATA, ST_RDRV
    } rx_state_e;

    rx_state_e         st;
    logic [PW-1:0]     pre_cnt;
    logic [4:0]        bit_cnt;
    logic [4:0]        fall_cnt;
    logic [HDR_W-2:0]  hdr_sh;
    logic [HALF_W-1:0] dat_sh;
    logic [HALF_W-1:0] tx_sh;
    logic [HDR_W-1:0]  hdr_full;
    logic [1:0]        hdr_op;
    mode_e             hdr_mode;

    assign hdr_full = {hdr_sh, mdio_s};
    assign hdr_op   = hdr_full[HDR_W-1 -: 2];
    assign hdr_mode = mode_e'(hdr_full[HDR_W-3 -: 2]);

    always_ff @(posedge clk) begin
        wr_evt     <= 1'b0;
        rd_evt     <= 1'b0;
        bypass_stb <= 1'b0;
        if (rst) begin
            st       <= ST_PRE;
            pre_cnt  <= '0;
            bit_cnt  <= '0;
            fall_cnt <= '0;
            hdr_sh   <= '0;
            dat_sh   <= '0;
            tx_sh    <= '0;
            req      <= '0;
            mdio_out <= 1'b0;
            mdio_oe  <= 1'b0;
        end else begin
            case (st)
                ST_PRE: if (rise) begin
                    if (mdio_s) begin
                        if (pre_cnt != PW'(PRE_MIN)) pre_cnt <= pre_cnt + 1'b1;
                    end else begin
                        if (pre_cnt == PW'(PRE_MIN)) st <= ST_START;
                        pre_cnt <= '0;
                    end
                end
                ST_START: if (rise) begin
                    st      <= mdio_s ? ST_HDR : ST_PRE;
                    bit_cnt <= '0;
                end
                ST_HDR: if (rise) begin
                    hdr_sh  <= hdr_full[HDR_W-2:0];
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == 5'(HDR_W - 1)) begin
                        req.mode   <= hdr_mode;
                        req.phy_lo <= hdr_full[REGN_W +: PHY_LO_W];
                        req.regn   <= hdr_full[REGN_W-1:0];
                        bit_cnt    <= '0;
                        fall_cnt   <= '0;
                        if (hdr_op != 2'b10 && hdr_op != 2'b01) begin
                            st <= ST_PRE;
                        end else if (hdr_mode != MODE_REG && hdr_mode != MODE_PAGE) begin
                            bypass_stb <= 1'b1;
                            st         <= ST_PRE;
                        end else if (hdr_op == 2'b10) begin
                            if (hdr_mode == MODE_REG) begin
                                rd_evt <= 1'b1;
                                st     <= ST_RDRV;
                            end else begin
                                st <= ST_PRE;
                            end
                        end else begin
                            st <= ST_WDATA;
                        end
                    end
                end
                ST_WDATA: if (rise) begin
                    dat_sh  <= {dat_sh[HALF_W-2:0], mdio_s};
                    bit_cnt <= bit_cnt + 1'b1;
                    if (bit_cnt == 5'(HALF_W + 1)) begin
                        req.data <= {dat_sh[HALF_W-2:0], mdio_s};
                        wr_evt   <= 1'b1;
                        st       <= ST_PRE;
                    end
                end
                ST_RDRV: if (fall) begin
                    fall_cnt <= fall_cnt + 1'b1;
                    if (fall_cnt == 5'd1) begin
                        mdio_oe  <= 1'b1;
                        mdio_out <= 1'b0;
                        tx_sh    <= rd_half;
                    end else if (fall_cnt >= 5'd2 && fall_cnt <= 5'(HALF_W + 1)) begin
                        mdio_out <= tx_sh[HALF_W-1];
                        tx_sh    <= {tx_sh[HALF_W-2:0], 1'b0};
                    end else if (fall_cnt == 5'(HALF_W + 2)) begin
                        mdio_oe  <= 1'b0;
                        mdio_out <= 1'b0;
                        st       <= ST_PRE;
                    end
                end
                default: st <= ST_PRE;
            endcase
        end
    end

    // R9: every driven window opens with the zero turnaround bit
    a_r9_ta_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> !mdio_out);

    // R1: a bypass frame never also raises a register event
    a_r1_bypass_alone: assert property (@(posedge clk) disable iff (rst)
        bypass_stb |-> !wr_evt && !rd_evt);

endmodule

// File: rtl/paged_reg_core.sv
module paged_reg_core
    import mdio_bridge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_evt,
    input  logic              rd_evt,
    input  mdio_req_t         req,
    input  logic [WORD_W-1:0] reg_rdata,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    output logic [HALF_W-1:0] rd_half
);
    logic [PAGE_W-1:0]  page;
    logic               stage_v;
    logic [WORD_AW-1:0] stage_word;
    logic [HALF_W-1:0]  stage_lo;
    logic               hold_v;
    logic [WORD_AW-1:0] hold_word;
    logic [HALF_W-1:0]  hold_hi;
    logic               cap_low;
    logic [WORD_AW-1:0] cur_word;
    logic               cur_high;

    assign cur_word = word_of(page, req.phy_lo, req.regn[REGN_W-1:1]);
    assign cur_high = req.regn[0];

    always_ff @(posedge clk) begin
        reg_wr <= 1'b0;
        reg_rd <= 1'b0;
        if (rst) begin
            page       <= '0;
            stage_v    <= 1'b0;
            stage_word <= '0;
            stage_lo   <= '0;
            hold_v     <= 1'b0;
            hold_word  <= '0;
            hold_hi    <= '0;
            cap_low    <= 1'b0;
            reg_addr   <= '0;
            reg_wdata  <= '0;
            rd_half    <= '0;
        end else begin
            if (reg_rd) begin
                if (cap_low) begin
                    rd_half   <= reg_rdata[HALF_W-1:0];
                    hold_hi   <= reg_rdata[WORD_W-1:HALF_W];
                    hold_word <= reg_addr[ADDR_W-1:2];
                    hold_v    <= 1'b1;
                end else begin
                    rd_half <= reg_rdata[WORD_W-1:HALF_W];
                end
            end
            if (wr_evt) begin
                case (req.mode)
                    MODE_PAGE: page <= req.data[PAGE_W-1:0];
                    MODE_REG: begin
                        if (!cur_high) begin
                            stage_v    <= 1'b1;
                            stage_word <= cur_word;
                            stage_lo   <= req.data;
                        end else if (stage_v && stage_word == cur_word) begin
                            reg_wr    <= 1'b1;
                            reg_addr  <= {cur_word, 2'b00};
                            reg_wdata <= {req.data, stage_lo};
                            stage_v   <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
            if (rd_evt && req.mode == MODE_REG) begin
                if (cur_high && hold_v && hold_word == cur_word) begin
                    rd_half <= hold_hi;
                    hold_v  <= 1'b0;
                end else begin
                    reg_rd   <= 1'b1;
                    reg_addr <= {cur_word, 2'b00};
                    cap_low  <= !cur_high;
                end
            end
        end
    end

    // R11: one strobe at a time, each one cycle wide
    a_r11_excl: assert property (@(posedge clk) disable iff (rst)
        !(reg_wr && reg_rd));
    a_r11_wr_pulse: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);
    // R5: a bus write only follows a decoded write frame
    a_r5_wr_cause: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> $past(wr_evt));
    // R6: a bus read only follows a decoded read frame
    a_r6_rd_cause: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> $past(rd_evt));
    // R2: the page moves only on a write frame
    a_r2_page_src: assert property (@(posedge clk) disable iff (rst)
        (page != $past(page)) |-> $past(wr_evt));

endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
    import mdio_bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PRE_MIN     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_out,
    output logic              mdio_oe,
    output logic              bypass_stb,
    output logic              reg_wr,
    output logic              reg_rd,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [WORD_W-1:0] reg_wdata,
    input  logic [WORD_W-1:0] reg_rdata
);
    logic              rise, fall, mdio_s;
    logic              wr_evt, rd_evt;
    mdio_req_t         req;
    logic [HALF_W-1:0] rd_half;

    mdio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .mdc_i    (mdc),
        .mdio_i   (mdio_in),
        .mdc_rise (rise),
        .mdc_fall (fall),
        .mdio_s   (mdio_s)
    );

    mdio_frame_rx #(.PRE_MIN(PRE_MIN)) u_rx (
        .clk        (clk),
        .rst        (rst),
        .rise       (rise),
        .fall       (fall),
        .mdio_s     (mdio_s),
        .rd_half    (rd_half),
        .wr_evt     (wr_evt),
        .rd_evt     (rd_evt),
        .req        (req),
        .bypass_stb (bypass_stb),
        .mdio_out   (mdio_out),
        .mdio_oe    (mdio_oe)
    );

    paged_reg_core u_core (
        .clk       (clk),
        .rst       (rst),
        .wr_evt    (wr_evt),
        .rd_evt    (rd_evt),
        .req       (req),
        .reg_rdata (reg_rdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .rd_half   (rd_half)
    );

    // R1: a bypass frame is followed by no bus access
    a_r1_bypass_quiet: assert property (@(posedge clk) disable iff (rst)
        bypass_stb |=> !reg_wr && !reg_rd);

endmodule

// File: tb/mdio_paged_bridge_tb.sv
module mdio_paged_bridge_tb;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst, mdc, mdio_m;
    logic        mdio_out, mdio_oe, bypass_stb, reg_wr, reg_rd;
    logic [18:0] reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic [31:0] salt;

    function automatic logic [31:0] rfn(input logic [18:0] a, input logic [31:0] s);
        return {a[15:0] ^ 16'h5A00, ~a[15:0]} ^ s;
    endfunction

    assign reg_rdata = rfn(reg_addr, salt);

    mdio_paged_bridge u_dut (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_in(mdio_m),
        .mdio_out(mdio_out), .mdio_oe(mdio_oe), .bypass_stb(bypass_stb),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    typedef struct {
        bit          is_wr;
        logic [18:0] addr;
        logic [31:0] data;
    } ev_t;
    ev_t expq[$];

    int total = 0, bad = 0, bypass_seen = 0;
    bit drive_ok = 1'b0, prev_wr = 1'b0, prev_rd = 1'b0;

    // reference state
    logic [9:0]  m_page;
    bit          m_sv, m_hv;
    logic [16:0] m_sw, m_hw;
    logic [15:0] m_slo, m_hhi;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison of bus strobes and pin drive against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (reg_wr && reg_rd) check(1'b0, "R11 both strobes", 1, 0);
            if ((reg_wr && prev_wr) || (reg_rd && prev_rd)) check(1'b0, "R11 strobe width", 2, 1);
            if (reg_wr || reg_rd) begin
                if (expq.size() == 0) begin
                    check(1'b0, "R4/R5/R6 unexpected bus op", {12'd0, reg_addr}, 0);
                end else begin
                    ev_t e;
                    e = expq.pop_front();
                    check(e.is_wr == reg_wr, "R5/R6 bus op kind", {31'd0, reg_wr}, {31'd0, e.is_wr});
                    check(e.addr == reg_addr, "R3 bus address", {13'd0, reg_addr}, {13'd0, e.addr});
                    if (e.is_wr) check(e.data == reg_wdata, "R5 write data", reg_wdata, e.data);
                end
            end
            if (mdio_oe && !drive_ok) check(1'b0, "R9/R10 drive outside read", 1, 0);
            if (bypass_stb) bypass_seen++;
        end
        prev_wr = reg_wr;
        prev_rd = reg_rd;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input bit b);
        mdio_m = b; mdc = 1'b0; tick(8);
        mdc = 1'b1; tick(8);
    endtask

    task automatic recv_bit(output bit v, output bit oe);
        mdio_m = 1'b1; mdc = 1'b0; tick(8);
        oe = mdio_oe;
        v  = mdio_oe ? mdio_out : 1'b1;
        mdc = 1'b1; tick(8);
    endtask

    task automatic header(input int pre, input bit [1:0] op, input bit [4:0] phy, input bit [4:0] rn);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0); send_bit(1'b1);
        for (int i = 1; i >= 0; i--) send_bit(op[i]);
        for (int i = 4; i >= 0; i--) send_bit(phy[i]);
        for (int i = 4; i >= 0; i--) send_bit(rn[i]);
    endtask

    task automatic model_reset();
        m_page = '0; m_sv = 0; m_hv = 0; m_sw = '0; m_hw = '0; m_slo = '0; m_hhi = '0;
    endtask

    // full write frame; model predicts bus activity
    task automatic do_write(input bit [4:0] phy, input bit [4:0] rn, input bit [15:0] d,
                            input int pre, input bit [1:0] op, input string tag);
        logic [16:0] w;
        w = {m_page, phy[2:0], rn[4:1]};
        if (pre >= 32 && op == 2'b01) begin
            if (phy[4:3] == 2'b11) m_page = d[9:0];
            else if (phy[4:3] == 2'b10) begin
                if (!rn[0]) begin m_sv = 1; m_sw = w; m_slo = d; end
                else if (m_sv && m_sw == w) begin
                    ev_t e; e.is_wr = 1; e.addr = {w, 2'b00}; e.data = {d, m_slo};
                    expq.push_back(e); m_sv = 0;
                end
            end
        end
        header(pre, op, phy, rn);
        send_bit(1'b1); send_bit(1'b0);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
        mdc = 1'b0; tick(8);
        check(expq.size() == 0, tag, expq.size(), 0);
    endtask

    task automatic do_read(input bit [4:0] phy, input bit [4:0] rn, input string tag);
        logic [16:0] w;
        logic [15:0] exp, got;
        logic [31:0] full;
        bit v, oe, drive;
        w     = {m_page, phy[2:0], rn[4:1]};
        full  = rfn({w, 2'b00}, salt);
        drive = (phy[4:3] == 2'b10);
        exp   = '0;
        if (drive) begin
            if (!rn[0]) begin
                ev_t e; e.is_wr = 0; e.addr = {w, 2'b00}; e.data = '0; expq.push_back(e);
                exp = full[15:0]; m_hv = 1; m_hw = w; m_hhi = full[31:16];
            end else if (m_hv && m_hw == w) begin
                exp = m_hhi; m_hv = 0;
            end else begin
                ev_t e; e.is_wr = 0; e.addr = {w, 2'b00}; e.data = '0; expq.push_back(e);
                exp = full[31:16];
            end
        end
        header(32, 2'b10, phy, rn);
        drive_ok = drive;
        recv_bit(v, oe);
        check(!oe, "R9 first turnaround released", {31'd0, oe}, 0);
        recv_bit(v, oe);
        if (drive) check(oe && !v, "R9 second turnaround zero", {30'd0, oe, v}, 32'h2);
        else       check(!oe, "R10 no drive in page/other read", {31'd0, oe}, 0);
        got = '0;
        for (int i = 0; i < 16; i++) begin
            recv_bit(v, oe);
            got = {got[14:0], v};
        end
        if (drive) check(got == exp, tag, {16'd0, got}, {16'd0, exp});
        recv_bit(v, oe);
        check(!oe, "R9 release after data", {31'd0, oe}, 0);
        drive_ok = 1'b0;
        check(expq.size() == 0, "R6/R7 bus reads as predicted", expq.size(), 0);
    endtask

    initial begin
        int bp;
        rst = 1'b1; mdc = 1'b0; mdio_m = 1'b1; salt = '0;
        model_reset();
        tick(6);
        rst = 1'b0;
        tick(3);
        check(!mdio_oe && !reg_wr && !reg_rd && !bypass_stb, "R11 reset idle outputs",
              {28'd0, mdio_oe, reg_wr, reg_rd, bypass_stb}, 0);

        // R4 then R5 with page 0 after reset (R2, R3)
        do_write(5'b10101, 5'd6, 16'h1234, 32, 2'b01, "R4 low write stages only");
        do_write(5'b10101, 5'd7, 16'hABCD, 32, 2'b01, "R5 merged write, R3 address");

        // R2 page load then access inside that window (R3)
        do_write(5'b11000, 5'd0, 16'hFEB5, 32, 2'b01, "R2 page write no bus op");
        do_write(5'b10010, 5'd30, 16'h0F0F, 32, 2'b01, "R4 low write in paged window");
        do_write(5'b10010, 5'd31, 16'h7777, 32, 2'b01, "R3 page supplies upper address");

        // R5 unmatched high halves are dropped
        do_write(5'b10000, 5'd3, 16'h1111, 32, 2'b01, "R5 high without low dropped");
        do_write(5'b10001, 5'd4, 16'h2222, 32, 2'b01, "R4 low stage");
        do_write(5'b10001, 5'd9, 16'h3333, 32, 2'b01, "R5 high to other word dropped");

        // R6 / R7 consistent read pair despite changing bus data
        salt = 32'h0000_0000;
        do_read(5'b10110, 5'd10, "R6 low half read data");
        salt = 32'hFFFF_0000;
        do_read(5'b10110, 5'd11, "R7 high half from kept value");
        do_read(5'b10110, 5'd13, "R7 high half fresh read");

        // R10 page is not readable
        do_read(5'b11000, 5'd0, "R10 page read");

        // R1 bypass modes
        bp = bypass_seen;
        do_write(5'b00011, 5'd2, 16'h5555, 32, 2'b01, "R1 bypass write no bus op");
        do_read(5'b01111, 5'd6, "R1 reserved mode read");
        check(bypass_seen == bp + 2, "R1 bypass strobe count", bypass_seen, bp + 2);

        // R8 bad opcodes and short preamble
        do_write(5'b10100, 5'd0, 16'h4242, 32, 2'b11, "R8 opcode 11 ignored");
        do_write(5'b10100, 5'd0, 16'h4343, 32, 2'b00, "R8 opcode 00 ignored");
        do_write(5'b10100, 5'd20, 16'h0102, 32, 2'b01, "R4 low before short frame");
        do_write(5'b10100, 5'd21, 16'h0304, 10, 2'b01, "R8 short preamble ignored");
        do_write(5'b10100, 5'd21, 16'h0506, 32, 2'b01, "R8 full frame accepted after");

        // R2 reset clears the page
        rst = 1'b1; tick(4); rst = 1'b0; model_reset(); tick(4);
        do_write(5'b10011, 5'd16, 16'hCAFE, 32, 2'b01, "R2 low after reset");
        do_write(5'b10011, 5'd17, 16'hBEEF, 32, 2'b01, "R2 page zero after reset");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule